// File: doc/BRIEF.md
# Packed-SIMD ALU with Dot Product

This execution unit operates on 32-bit words that hold either four 8-bit lanes or two 16-bit lanes. Each issued operation computes a lane-wise result (wrapping add, minimum, maximum, comparison masks, lane shuffle, half-word pack) or a reduction (dot product across all lanes, optionally added to an accumulator input). The result is captured in a register and is presented one cycle after the operation is issued, together with a valid strobe.

A replication flag lets a scalar held in the lowest lane of the second operand act on every lane. With it, a vector-by-scalar operation needs no separate broadcast step. Signed and unsigned variants of minimum, maximum and dot product share one opcode slot and are told apart by opcode bit 0. The accumulating dot products are told apart from the plain ones by opcode bit 1.

Top module: `simd_alu`

## Requirements
- R1: While rst_ni is low, and after its release until the first issued operation, result_o and valid_o are zero.
- R2: valid_o is high in exactly the cycle after a cycle with valid_i high. result_o changes only one cycle after valid_i is high, and holds its value otherwise.
- R3: Opcode 0 adds lanes modulo the lane width. No carry passes between lanes. half_mode_i=0 selects four 8-bit lanes, and half_mode_i=1 selects two 16-bit lanes, lane 0 in the low bits.
- R4: Opcodes 2/3 give the lane minimum and opcodes 4/5 give the lane maximum. The even code compares unsigned and the odd code compares two's-complement signed.
- R5: Opcodes 6 (equal), 7 (not equal), 8 (unsigned less-than) and 9 (signed less-than) set a result lane to all ones when the condition holds for a<b lanes, and to all zeros when it does not.
- R6: Opcode 10 (shuffle) sets result lane i to the lane of a_i whose index is in the low bits of lane i of the second operand: 2 bits for 8-bit lanes, 1 bit for 16-bit lanes. Higher bits are ignored.
- R7: Opcode 11 (pack) gives {second operand[15:0], a_i[15:0]}.
- R8: With repl_i=1, the lowest lane of b_i (bits 7:0 or 15:0, by mode) replaces every lane of the second operand before any operation.
- R9: Opcodes 12 (unsigned) and 13 (signed) in 8-bit mode give the sum of the four lane products a×b, modulo 2^32.
- R10: Opcodes 12 and 13 in 16-bit mode give the sum of the two 16×16 lane products, modulo 2^32.
- R11: Opcodes 14 (unsigned) and 15 (signed) give the dot product of R9/R10 plus acc_i, truncated to 32 bits.
- R12: Opcode 1 is reserved and yields a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 4 | Opcode |
| half_mode_i | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| repl_i | input | 1 | Replicate the lowest lane of b_i |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_i | input | 32 | Accumulator for opcodes 14 and 15 |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | Result valid strobe |

## Verification
The properties assume that valid_i stays low while rst_ni is asserted. They also assume that op_i, half_mode_i, repl_i and the operands carry defined values in every cycle where valid_i is high, because the lane-level checks look one cycle back at those inputs. The bench holds valid_i low throughout reset. It changes every input only on the falling clock edge, and it always drives fully defined operand patterns, including during the idle cycles used to show that the result holds.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_RSVD   = 4'd1,
    OP_MINU   = 4'd2,
    OP_MINS   = 4'd3,
    OP_MAXU   = 4'd4,
    OP_MAXS   = 4'd5,
    OP_CMPEQ  = 4'd6,
    OP_CMPNE  = 4'd7,
    OP_CMPLTU = 4'd8,
    OP_CMPLTS = 4'd9,
    OP_SHUF   = 4'd10,
    OP_PACK   = 4'd11,
    OP_DOTU   = 4'd12,
    OP_DOTS   = 4'd13,
    OP_ACCU   = 4'd14,
    OP_ACCS   = 4'd15
  } simd_op_e;
endpackage

// File: rtl/simd_operand_prep.sv
module simd_operand_prep #(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [WORD_W-1:0] b_i,
  input  logic              repl_i,
  output logic [WORD_W-1:0] b_o
);
  localparam int LANES = WORD_W / LANE_W;

  assign b_o = repl_i ? {LANES{b_i[LANE_W-1:0]}} : b_i;
endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [3:0]        op_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic [WORD_W-1:0] lane_res_o,
  output logic [WORD_W-1:0] dot_o
);
  localparam int LANES = WORD_W / LANE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int EXT_W = WORD_W - LANE_W;

  logic sgn;
  logic [LANES-1:0][LANE_W-1:0] res;
  logic [LANES-1:0][WORD_W-1:0] prod;

  assign sgn = op_i[0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, sum, pick;
    logic [IDX_W-1:0]  idx;
    logic              lt_u, lt_s, lt, eq;
    logic [WORD_W-1:0] ax, bx;

    assign la   = a_i[g*LANE_W +: LANE_W];
    assign lb   = b_i[g*LANE_W +: LANE_W];
    assign sum  = la + lb;
    assign idx  = lb[IDX_W-1:0];
    assign pick = a_i[idx*LANE_W +: LANE_W];
    assign lt_u = la < lb;
    assign lt_s = $signed(la) < $signed(lb);
    assign lt   = sgn ? lt_s : lt_u;
    assign eq   = la == lb;
    // extend per signedness so a 32-bit product is exact modulo 2^32
    assign ax   = sgn ? {{EXT_W{la[LANE_W-1]}}, la} : {{EXT_W{1'b0}}, la};
    assign bx   = sgn ? {{EXT_W{lb[LANE_W-1]}}, lb} : {{EXT_W{1'b0}}, lb};
    assign prod[g] = ax * bx;

    always_comb begin
      unique case (simd_op_e'(op_i))
        OP_ADD:             res[g] = sum;
        OP_MINU, OP_MINS:   res[g] = lt ? la : lb;
        OP_MAXU, OP_MAXS:   res[g] = lt ? lb : la;
        OP_CMPEQ:           res[g] = {LANE_W{eq}};
        OP_CMPNE:           res[g] = {LANE_W{~eq}};
        OP_CMPLTU:          res[g] = {LANE_W{lt_u}};
        OP_CMPLTS:          res[g] = {LANE_W{lt_s}};
        OP_SHUF:            res[g] = pick;
        default:            res[g] = '0;
      endcase
    end
  end

  always_comb begin
    dot_o = '0;
    for (int i = 0; i < LANES; i++) dot_o = dot_o + prod[i];
  end

  assign lane_res_o = res;
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic              half_mode_i,
  input  logic              repl_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] acc_i,
  output logic [WORD_W-1:0] result_o,
  output logic              valid_o
);
  localparam int NMODES = 2;
  localparam int HALF_W = WORD_W / 2;

  logic [NMODES-1:0][WORD_W-1:0] mode_b, mode_res, mode_dot;
  logic [WORD_W-1:0] b_sel, res_sel, dot_sel, nxt;

  // mode g uses lanes of BYTE_W << g bits
  for (genvar g = 0; g < NMODES; g++) begin : g_mode
    simd_operand_prep #(.WORD_W(WORD_W), .LANE_W(BYTE_W << g)) u_prep (
      .b_i   (b_i),
      .repl_i(repl_i),
      .b_o   (mode_b[g])
    );
    simd_lane_unit #(.WORD_W(WORD_W), .LANE_W(BYTE_W << g)) u_unit (
      .op_i      (op_i),
      .a_i       (a_i),
      .b_i       (mode_b[g]),
      .lane_res_o(mode_res[g]),
      .dot_o     (mode_dot[g])
    );
  end

  assign b_sel   = mode_b[half_mode_i];
  assign res_sel = mode_res[half_mode_i];
  assign dot_sel = mode_dot[half_mode_i];

  always_comb begin
    unique case (simd_op_e'(op_i))
      OP_PACK:           nxt = {b_sel[HALF_W-1:0], a_i[HALF_W-1:0]};
      OP_DOTU, OP_DOTS:  nxt = dot_sel;
      OP_ACCU, OP_ACCS:  nxt = dot_sel + acc_i;
      default:           nxt = res_sel;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= nxt;
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk
  import simd_alu_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [3:0]        op_i,
  input logic              half_mode_i,
  input logic              repl_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] result_o,
  input logic              valid_o
);
  localparam int NB = WORD_W / BYTE_W;
  localparam int HW = 2 * BYTE_W;
  localparam int NH = WORD_W / HW;

  logic [NB-1:0] byte_ok;
  logic [NH-1:0] half_ok;
  logic          is_cmp;

  for (genvar g = 0; g < NB; g++) begin : g_b
    assign byte_ok[g] = (result_o[g*BYTE_W +: BYTE_W] == '0) || (&result_o[g*BYTE_W +: BYTE_W]);
  end
  for (genvar g = 0; g < NH; g++) begin : g_h
    assign half_ok[g] = (result_o[g*HW +: HW] == '0) || (&result_o[g*HW +: HW]);
  end

  assign is_cmp = (op_i >= OP_CMPEQ) && (op_i <= OP_CMPLTS);

  p_valid_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> $stable(result_o));

  p_lane_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_ADD && !half_mode_i && !repl_i) |->
      result_o[2*BYTE_W-1:BYTE_W] == BYTE_W'($past(a_i[2*BYTE_W-1:BYTE_W]) + $past(b_i[2*BYTE_W-1:BYTE_W])));

  p_max_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_MAXU && !half_mode_i && !repl_i) |->
      (result_o[BYTE_W-1:0] >= $past(a_i[BYTE_W-1:0])) && (result_o[BYTE_W-1:0] >= $past(b_i[BYTE_W-1:0])));

  p_cmp_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && is_cmp) |-> ($past(half_mode_i) ? (&half_ok) : (&byte_ok)));

  p_repl_pack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_PACK && repl_i && !half_mode_i) |->
      result_o[WORD_W-1:HW] == {2{$past(b_i[BYTE_W-1:0])}});

  p_rsvd_zero_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && op_i == OP_RSVD) |-> result_o == '0);
endmodule

bind simd_alu simd_alu_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .half_mode_i(half_mode_i), .repl_i(repl_i), .a_i(a_i), .b_i(b_i),
  .result_o(result_o), .valid_o(valid_o)
);

// File: tb/simd_alu_tb_top.sv
module simd_alu_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        half_mode_i = 1'b0;
  logic        repl_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, acc_i = '0;
  logic [31:0] result_o;
  logic        valid_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  simd_alu dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .half_mode_i(half_mode_i), .repl_i(repl_i), .a_i(a_i), .b_i(b_i),
    .acc_i(acc_i), .result_o(result_o), .valid_o(valid_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [3:0] op, input logic half, input logic repl,
                     input logic [31:0] a, input logic [31:0] b, input logic [31:0] acc,
                     input logic [31:0] exp);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; half_mode_i = half; repl_i = repl;
    a_i = a; b_i = b; acc_i = acc;
    @(negedge clk_i);
    check({tag, " valid"}, {31'd0, valid_o}, 32'd1);
    check(tag, result_o, exp);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 result in reset", result_o, 32'h0);
    check("R1 valid in reset", {31'd0, valid_o}, 32'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 result after release", result_o, 32'h0);
    check("R1 valid after release", {31'd0, valid_o}, 32'h0);
  endtask

  task automatic t_add();
    run("R3 add 8b carry isolation", 4'd0, 1'b0, 1'b0, 32'h01FF7F80, 32'h01010180, 0, 32'h02008000);
    run("R3 add 16b", 4'd0, 1'b1, 1'b0, 32'h1234FFFF, 32'h00010002, 0, 32'h12350001);
  endtask

  task automatic t_minmax();
    run("R4 minu 8b", 4'd2, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'h01107F05);
    run("R4 mins 8b", 4'd3, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'h80108005);
    run("R4 maxu 8b", 4'd4, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'h80208005);
    run("R4 maxs 8b", 4'd5, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'h01207F05);
    run("R4 mins 16b", 4'd3, 1'b1, 1'b0, 32'h80000003, 32'h0001FFFF, 0, 32'h8000FFFF);
  endtask

  task automatic t_compare();
    run("R5 eq 8b", 4'd6, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'h000000FF);
    run("R5 ne 8b", 4'd7, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'hFFFFFF00);
    run("R5 ltu 8b", 4'd8, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'h00FFFF00);
    run("R5 lts 8b", 4'd9, 1'b0, 1'b0, 32'h80107F05, 32'h01208005, 0, 32'hFFFF0000);
    run("R5 lts 16b", 4'd9, 1'b1, 1'b0, 32'h80000003, 32'h0001FFFF, 0, 32'hFFFF0000);
  endtask

  task automatic t_shuffle();
    run("R6 shuffle 8b", 4'd10, 1'b0, 1'b0, 32'h44332211, 32'h00010203, 0, 32'h11223344);
    run("R6 shuffle 8b high index bits", 4'd10, 1'b0, 1'b0, 32'h44332211, 32'hFCFDFEFF, 0, 32'h11223344);
    run("R6 shuffle 16b", 4'd10, 1'b1, 1'b0, 32'hBBBBAAAA, 32'h00000001, 0, 32'hAAAABBBB);
  endtask

  task automatic t_pack();
    run("R7 pack 16b", 4'd11, 1'b1, 1'b0, 32'h11112222, 32'h33334444, 0, 32'h44442222);
    run("R7 pack 8b", 4'd11, 1'b0, 1'b0, 32'hDEADBEEF, 32'h01234567, 0, 32'h4567BEEF);
  endtask

  task automatic t_repl();
    run("R8 repl add 8b", 4'd0, 1'b0, 1'b1, 32'h10203040, 32'hAAAAAA05, 0, 32'h15253545);
    run("R8 repl maxu 16b", 4'd4, 1'b1, 1'b1, 32'h00019000, 32'hFFFF8000, 0, 32'h80009000);
    run("R8 repl dotu 8b", 4'd12, 1'b0, 1'b1, 32'h01010101, 32'h77665503, 0, 32'h0000000C);
    run("R8 repl pack 8b", 4'd11, 1'b0, 1'b1, 32'h0000BEEF, 32'h123456A5, 0, 32'hA5A5BEEF);
  endtask

  task automatic t_dot8();
    run("R9 dotu 8b", 4'd12, 1'b0, 1'b0, 32'h04030201, 32'h08070605, 0, 32'h00000046);
    run("R9 dotu 8b max", 4'd12, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 32'h0003F804);
    run("R9 dots 8b negative", 4'd13, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h01020304, 0, 32'hFFFFFFF6);
    run("R9 dots 8b min*min", 4'd13, 1'b0, 1'b0, 32'h80808080, 32'h80808080, 0, 32'h00010000);
  endtask

  task automatic t_dot16();
    run("R10 dotu 16b wrap", 4'd12, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 32'hFFFC0002);
    run("R10 dots 16b", 4'd13, 1'b1, 1'b0, 32'h80000002, 32'h8000FFFD, 0, 32'h3FFFFFFA);
  endtask

  task automatic t_acc();
    run("R11 accu 8b", 4'd14, 1'b0, 1'b0, 32'h04030201, 32'h08070605, 32'h00000100, 32'h00000146);
    run("R11 accu 16b truncation", 4'd14, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00040000, 32'h00000002);
    run("R11 accs 8b", 4'd15, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h01020304, 32'h0000000A, 32'h00000000);
    run("R11 dotu ignores acc", 4'd12, 1'b0, 1'b0, 32'h04030201, 32'h08070605, 32'h00001000, 32'h00000046);
  endtask

  task automatic t_rsvd();
    run("R12 preload", 4'd0, 1'b0, 1'b0, 32'h11111111, 32'h11111111, 0, 32'h22222222);
    run("R12 reserved op", 4'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000);
  endtask

  task automatic t_hold();
    run("R2 hold preload", 4'd0, 1'b0, 1'b0, 32'h01020304, 32'h10101010, 0, 32'h11121314);
    for (int k = 0; k < 3; k++) begin
      op_i = 4'd12; a_i = 32'hFFFFFFFF; b_i = 32'hFFFFFFFF; acc_i = 32'h5;
      @(negedge clk_i);
      check("R2 result held while idle", result_o, 32'h11121314);
      check("R2 valid low while idle", {31'd0, valid_o}, 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    t_add();
    t_minmax();
    t_compare();
    t_shuffle();
    t_pack();
    t_repl();
    t_dot8();
    t_dot16();
    t_acc();
    t_rsvd();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule